// File: doc/BRIEF.md
# Cached DRAM Bus Controller

This block drives one bank of DRAM with an on-chip row cache from the external bus of a 32-bit signal processor. It watches the bus strobe, the read/write line, the processor's reset and a periodic refresh request. From these it sequences row enable, the column address latch, write enable, a combined output-enable line, the refresh-mode pin and chip select. It also drives the ready line that holds the processor in wait states. The row/column address multiplexer that feeds the memory's shared address pins is part of the block.

The block runs from a clock at twice the bus rate. An internal phase bit splits each bus cycle into a first half (phase 0) and a second half (phase 1). Every control output is a flop, updated on each fast edge. The bus inputs are sampled and the state advances only on the fast edge that closes phase 1. This gives half-cycle strobes without combinational glitches.

Seven states are used. A read miss costs one wait state. Further reads from the open row loop in the read-hit state at one per bus cycle. A write takes two bus cycles with no wait. A refresh request that arrives during an access is held and served after the access's second cycle. While the processor is in reset, the block runs refresh cycles one after another.

Top module: `cdram_bus_ctrl`

## Requirements
- R1: After `rstN` is released the block is idle in phase 0. In idle, `procReady`=1 and `rowSelect`=1, and every other control output is 0.
- R2: While `hostReset`=1 the block repeats refresh1, refresh2, idle. Holding `hostReset` for 24 bus cycles from idle gives exactly 8 refreshes.
- R3: In idle, `hostReset` or `refreshReq` moves the block to refresh1 even when a strobe is present. Otherwise strobe with `busRead`=0 goes to write1, and strobe with `busRead`=1 goes to read1.
- R4: A read miss is read1 then read2. In read1, `procReady`=0 for both halves, `chipSelect`=`outEnable`=1, `rowSelect`=1 in phase 0, and `colSelect`=`rowEnable`=1 in phase 1.
- R5: In read2, `procReady`=`chipSelect`=`outEnable`=`rowEnable`=`colSelect`=1. While strobe and read stay active, the block stays in read2 with no wait state.
- R6: A write is write1 then write2 with `procReady`=1 throughout. In write1, `rowSelect`=1 in phase 0, and `colSelect`=`rowEnable`=`writeEnable`=1 in phase 1. In write2, `colSelect`=1 in both halves, and `rowEnable`=`writeEnable`=`colLatch`=1 in phase 0 only. A write strobe in write2 goes straight to write1.
- R7: A read strobe in write2 goes straight to read1.
- R8: A `refreshReq` seen during read1, read2, write1 or write2 is held. The block enters refresh1 from read2 or write2, after the access's second cycle.
- R9: In refresh1, `refreshMode`=1 in both halves and `rowEnable`=1 in phase 1. In refresh2, `rowEnable`=1 in phase 0. In both refresh states `procReady`=0 and `chipSelect`=0. Refresh2 always returns to idle.
- R10: `memAddrMux` equals `busAddr[7:0]` when `colSelect`=1, and `busAddr[15:8]` otherwise. `memAddrDirect` always equals `busAddr[18:16]`.
- R11: `chipSelect` and `outEnable` are 0 in idle. `outEnable` is 1 only in read1 and read2.
- R12: From read2, a missing strobe or a write strobe returns the block to idle. `hostReset` in read2 or write2 also returns it to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus rate |
| rstN | input | 1 | Asynchronous active-low reset of the block's flops |
| hostReset | input | 1 | Processor held in reset; forces refresh cycles |
| busStrobe | input | 1 | Active-high external access strobe |
| busRead | input | 1 | 1 = read, 0 = write |
| busAddr | input | 19 | Processor word address |
| refreshReq | input | 1 | Periodic refresh request pulse |
| procReady | output | 1 | 1 = processor may complete this bus cycle |
| chipSelect | output | 1 | Memory chip select |
| rowEnable | output | 1 | Memory row enable |
| colLatch | output | 1 | Column address latch strobe |
| writeEnable | output | 1 | Memory write enable |
| outEnable | output | 1 | Combined read/output-enable line |
| refreshMode | output | 1 | Refresh-mode select |
| rowSelect | output | 1 | Row half of the address multiplexer enabled |
| colSelect | output | 1 | Column half of the address multiplexer enabled |
| memAddrMux | output | 8 | Multiplexed memory address pins |
| memAddrDirect | output | 3 | Upper row bits, wired straight through |

## Verification
Read bursts are run with hit runs of zero to three cycles at swept addresses. These separate the one-wait miss from the zero-wait hit loop, and show whether the multiplexer flips at the half-cycle. Write runs of one to three back-to-back accesses, and a write followed directly by a read, test whether write2 chains to write1 or read1 instead of falling to idle. Refresh requests are placed in idle beside a strobe, in the first and second cycle of a read, and in a write; the three timings separate immediate service from deferral to the end of the access. A held processor reset is counted for its number of refreshes, and reset is also raised inside accesses.

// File: rtl/cdram_pkg.sv
package cdram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REF1 = 3'd1,
    ST_REF2 = 3'd2,
    ST_RD1  = 3'd3,
    ST_RD2  = 3'd4,
    ST_WR1  = 3'd5,
    ST_WR2  = 3'd6
  } ctrlState_t;

  typedef struct packed {
    logic ready;
    logic cs;
    logic oe;
    logic rowEn;
    logic colLat;
    logic we;
    logic refMode;
    logic rowSel;
    logic colSel;
  } pinSet_t;

  typedef struct packed {
    logic colSel;
  } muxStrobe_t;

  function automatic pinSet_t decodePins(ctrlState_t st, logic ph);
    pinSet_t p;
    p = '0;
    case (st)
      ST_IDLE: begin
        p.ready  = 1'b1;
        p.rowSel = 1'b1;
      end
      ST_REF1: begin
        p.refMode = 1'b1;
        p.rowEn   = ph;
      end
      ST_REF2: begin
        p.rowEn = ~ph;
      end
      ST_RD1: begin
        p.cs     = 1'b1;
        p.oe     = 1'b1;
        p.rowEn  = ph;
        p.rowSel = ~ph;
        p.colSel = ph;
      end
      ST_RD2: begin
        p.ready  = 1'b1;
        p.cs     = 1'b1;
        p.oe     = 1'b1;
        p.rowEn  = 1'b1;
        p.colSel = 1'b1;
      end
      ST_WR1: begin
        p.ready  = 1'b1;
        p.cs     = 1'b1;
        p.rowEn  = ph;
        p.we     = ph;
        p.rowSel = ~ph;
        p.colSel = ph;
      end
      ST_WR2: begin
        p.ready  = 1'b1;
        p.cs     = 1'b1;
        p.rowEn  = ~ph;
        p.colLat = ~ph;
        p.we     = ~ph;
        p.colSel = 1'b1;
      end
      default: p = '0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/cdram_ctrl_fsm.sv
module cdram_ctrl_fsm
  import cdram_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostReset,
  input  logic       busStrobe,
  input  logic       busRead,
  input  logic       refreshReq,
  output pinSet_t    pins,
  output muxStrobe_t muxCtl
);

  ctrlState_t state, stateNext, busNext;
  logic       phase;
  logic       refPending;
  logic       inAccess;
  logic       refWanted;
  pinSet_t    pinsNext;

  assign inAccess  = (state == ST_RD1) || (state == ST_RD2) ||
                     (state == ST_WR1) || (state == ST_WR2);
  assign refWanted = refreshReq || refPending;

  // State choice taken at the close of a bus cycle
  always_comb begin
    busNext = ST_IDLE;
    case (state)
      ST_IDLE: begin
        if (hostReset || refWanted)      busNext = ST_REF1;
        else if (busStrobe && !busRead)  busNext = ST_WR1;
        else if (busStrobe && busRead)   busNext = ST_RD1;
        else                             busNext = ST_IDLE;
      end
      ST_REF1: busNext = ST_REF2;
      ST_REF2: busNext = ST_IDLE;
      ST_RD1:  busNext = ST_RD2;
      ST_RD2: begin
        if (hostReset)                   busNext = ST_IDLE;
        else if (refWanted)              busNext = ST_REF1;
        else if (busStrobe && busRead)   busNext = ST_RD2;
        else                             busNext = ST_IDLE;
      end
      ST_WR1:  busNext = ST_WR2;
      ST_WR2: begin
        if (hostReset)                   busNext = ST_IDLE;
        else if (refWanted)              busNext = ST_REF1;
        else if (busStrobe && !busRead)  busNext = ST_WR1;
        else if (busStrobe && busRead)   busNext = ST_RD1;
        else                             busNext = ST_IDLE;
      end
      default: busNext = ST_IDLE;
    endcase
  end

  assign stateNext = phase ? busNext : state;
  assign pinsNext  = decodePins(stateNext, ~phase);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      phase      <= 1'b0;
      refPending <= 1'b0;
      pins       <= decodePins(ST_IDLE, 1'b0);
    end else begin
      state      <= stateNext;
      phase      <= ~phase;
      refPending <= (refPending && (state != ST_REF1)) ||
                    (refreshReq && inAccess);
      pins       <= pinsNext;
    end
  end

  assign muxCtl.colSel = pins.colSel;

endmodule

// File: rtl/cdram_addr_mux.sv
module cdram_addr_mux
  import cdram_pkg::*;
#(
  parameter int COL_BITS = 8,
  parameter int ROW_BITS = 11,
  localparam int ADDR_W  = COL_BITS + ROW_BITS,
  localparam int DIRECT  = ROW_BITS - COL_BITS
) (
  input  logic [ADDR_W-1:0]   busAddr,
  input  muxStrobe_t          muxCtl,
  output logic [COL_BITS-1:0] memAddrMux,
  output logic [DIRECT-1:0]   memAddrDirect
);

  for (genvar b = 0; b < COL_BITS; b++) begin : g_lane
    assign memAddrMux[b] = muxCtl.colSel ? busAddr[b] : busAddr[COL_BITS + b];
  end

  assign memAddrDirect = busAddr[ADDR_W-1 -: DIRECT];

endmodule

// File: rtl/cdram_bus_ctrl.sv
module cdram_bus_ctrl
  import cdram_pkg::*;
#(
  parameter int COL_BITS = 8,
  parameter int ROW_BITS = 11,
  localparam int ADDR_W  = COL_BITS + ROW_BITS,
  localparam int DIRECT  = ROW_BITS - COL_BITS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostReset,
  input  logic                busStrobe,
  input  logic                busRead,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                refreshReq,
  output logic                procReady,
  output logic                chipSelect,
  output logic                rowEnable,
  output logic                colLatch,
  output logic                writeEnable,
  output logic                outEnable,
  output logic                refreshMode,
  output logic                rowSelect,
  output logic                colSelect,
  output logic [COL_BITS-1:0] memAddrMux,
  output logic [DIRECT-1:0]   memAddrDirect
);

  pinSet_t    pins;
  muxStrobe_t muxCtl;

  cdram_ctrl_fsm u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .hostReset  (hostReset),
    .busStrobe  (busStrobe),
    .busRead    (busRead),
    .refreshReq (refreshReq),
    .pins       (pins),
    .muxCtl     (muxCtl)
  );

  cdram_addr_mux #(.COL_BITS(COL_BITS), .ROW_BITS(ROW_BITS)) u_mux (
    .busAddr       (busAddr),
    .muxCtl        (muxCtl),
    .memAddrMux    (memAddrMux),
    .memAddrDirect (memAddrDirect)
  );

  assign procReady   = pins.ready;
  assign chipSelect  = pins.cs;
  assign rowEnable   = pins.rowEn;
  assign colLatch    = pins.colLat;
  assign writeEnable = pins.we;
  assign outEnable   = pins.oe;
  assign refreshMode = pins.refMode;
  assign rowSelect   = pins.rowSel;
  assign colSelect   = pins.colSel;

endmodule

// File: rtl/cdram_bus_ctrl_checker.sv
module cdram_bus_ctrl_checker #(
  parameter int COL_BITS = 8,
  parameter int ROW_BITS = 11,
  localparam int ADDR_W  = COL_BITS + ROW_BITS
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              procReady,
  input logic              chipSelect,
  input logic              rowEnable,
  input logic              colLatch,
  input logic              writeEnable,
  input logic              outEnable,
  input logic              refreshMode,
  input logic              rowSelect,
  input logic              colSelect
);

  a_r11_oe_needs_cs: assert property (@(posedge clk) disable iff (!rstN)
    outEnable |-> chipSelect);

  a_r9_refresh_quiet: assert property (@(posedge clk) disable iff (!rstN)
    refreshMode |-> (!chipSelect && !procReady && !outEnable));

  a_r6_latch_with_we: assert property (@(posedge clk) disable iff (!rstN)
    colLatch |-> (writeEnable && colSelect && rowEnable));

  a_r10_one_select: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rowSelect, colSelect}));

  a_r4_miss_one_wait: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(procReady) && outEnable) |=> (!procReady ##1 procReady));

  a_r9_refresh_row_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $fell(refreshMode) |-> rowEnable);

endmodule

bind cdram_bus_ctrl cdram_bus_ctrl_checker #(.COL_BITS(COL_BITS), .ROW_BITS(ROW_BITS)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busAddr     (busAddr),
  .procReady   (procReady),
  .chipSelect  (chipSelect),
  .rowEnable   (rowEnable),
  .colLatch    (colLatch),
  .writeEnable (writeEnable),
  .outEnable   (outEnable),
  .refreshMode (refreshMode),
  .rowSelect   (rowSelect),
  .colSelect   (colSelect)
);

// File: tb/cdram_bus_ctrl_test.sv
`timescale 1ns/1ps
module cdram_bus_ctrl_test;

  localparam int COL_BITS = 8;
  localparam int ROW_BITS = 11;
  localparam int ADDR_W   = COL_BITS + ROW_BITS;
  localparam int DIRECT   = ROW_BITS - COL_BITS;

  localparam int S_I  = 0;
  localparam int S_F1 = 1;
  localparam int S_F2 = 2;
  localparam int S_R1 = 3;
  localparam int S_R2 = 4;
  localparam int S_W1 = 5;
  localparam int S_W2 = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostReset = 1'b0, busStrobe = 1'b0, busRead = 1'b0, refreshReq = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic procReady, chipSelect, rowEnable, colLatch, writeEnable, outEnable;
  logic refreshMode, rowSelect, colSelect;
  logic [COL_BITS-1:0] memAddrMux;
  logic [DIRECT-1:0]   memAddrDirect;

  int checks = 0;
  int fails  = 0;
  int refSeen = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cdram_bus_ctrl uut (
    .clk(clk), .rstN(rstN), .hostReset(hostReset), .busStrobe(busStrobe),
    .busRead(busRead), .busAddr(busAddr), .refreshReq(refreshReq),
    .procReady(procReady), .chipSelect(chipSelect), .rowEnable(rowEnable),
    .colLatch(colLatch), .writeEnable(writeEnable), .outEnable(outEnable),
    .refreshMode(refreshMode), .rowSelect(rowSelect), .colSelect(colSelect),
    .memAddrMux(memAddrMux), .memAddrDirect(memAddrDirect)
  );

  // Spec table: {ready, cs, oe, rowEn, colLat, we, refMode, rowSel, colSel}
  function automatic logic [8:0] specPins(int st, bit ph);
    case (st)
      S_I:  return {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
      S_F1: return {1'b0, 1'b0, 1'b0, ph,   1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
      S_F2: return {1'b0, 1'b0, 1'b0, !ph,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
      S_R1: return {1'b0, 1'b1, 1'b1, ph,   1'b0, 1'b0, 1'b0, !ph,  ph};
      S_R2: return {1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
      S_W1: return {1'b1, 1'b1, 1'b0, ph,   1'b0, ph,   1'b0, !ph,  ph};
      S_W2: return {1'b1, 1'b1, 1'b0, !ph,  !ph,  !ph,  1'b0, 1'b0, 1'b1};
      default: return '0;
    endcase
  endfunction

  task automatic chk(int st, bit ph, string tag);
    logic [8:0] act, exp;
    logic [COL_BITS-1:0] expMux;
    act = {procReady, chipSelect, outEnable, rowEnable, colLatch, writeEnable,
           refreshMode, rowSelect, colSelect};
    exp = specPins(st, ph);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s state=%0d phase=%0d pins actual=%b expected=%b", tag, st, ph, act, exp);
    end
    expMux = exp[0] ? busAddr[COL_BITS-1:0] : busAddr[2*COL_BITS-1:COL_BITS];
    checks++;
    if (memAddrMux !== expMux || memAddrDirect !== busAddr[ADDR_W-1 -: DIRECT]) begin
      fails++;
      $display("FAIL R10 state=%0d phase=%0d addr actual=%h/%h expected=%h/%h", st, ph,
               memAddrMux, memAddrDirect, expMux, busAddr[ADDR_W-1 -: DIRECT]);
    end
  endtask

  // One bus cycle: inputs held for both halves, state st expected throughout
  task automatic cyc(bit s, bit r, bit q, bit h, int st, string tag);
    busStrobe = s; busRead = r; refreshReq = q; hostReset = h;
    #1;
    chk(st, 1'b0, tag);
    @(negedge clk);
    #1;
    chk(st, 1'b1, tag);
    if (refreshMode) refSeen++;
    @(negedge clk);
  endtask

  task automatic scalar(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: idle after reset
    cyc(0, 0, 0, 0, S_I, "R1");

    // R2: host reset held 24 bus cycles -> 8 refreshes
    refSeen = 0;
    cyc(0, 0, 0, 1, S_I, "R2");
    for (int k = 0; k < 8; k++) begin
      cyc(0, 0, 0, 1, S_F1, "R2_R9");
      cyc(0, 0, 0, 1, S_F2, "R2_R9");
      cyc(0, 0, 0, (k < 7), S_I, "R2");
    end
    scalar(refSeen == 8, "R2 refresh count", refSeen, 8);

    // R3: refresh request beats a read strobe in idle
    busAddr = 19'h2A5C3;
    cyc(1, 1, 1, 0, S_I, "R3");
    cyc(1, 1, 0, 0, S_F1, "R3_R9");
    cyc(1, 1, 0, 0, S_F2, "R3_R9");
    cyc(1, 1, 0, 0, S_I, "R3");
    cyc(0, 0, 0, 0, S_R1, "R3_R4");
    cyc(0, 0, 0, 0, S_R2, "R12");
    cyc(0, 0, 0, 0, S_I, "R11");
    // R3: host reset beats a write strobe
    cyc(1, 0, 0, 1, S_I, "R3");
    cyc(0, 0, 0, 0, S_F1, "R3");
    cyc(0, 0, 0, 0, S_F2, "R3");

    // R4 R5 R10 R12: read bursts, swept addresses and hit lengths
    for (int b = 0; b < 12; b++) begin
      busAddr = ADDR_W'((b * 24593 + 977) % (1 << ADDR_W));
      cyc(1, 1, 0, 0, S_I, "R4");
      cyc(1, 1, 0, 0, S_R1, "R4");
      for (int h = 0; h < b % 4; h++) begin
        cyc(1, 1, 0, 0, S_R2, "R5");
        busAddr = busAddr + ADDR_W'(1);
      end
      cyc((b % 2) == 1, 0, 0, 0, S_R2, "R12");
      cyc(0, 0, 0, 0, S_I, "R12");
    end

    // R6 R7: write runs then read straight after a write
    for (int n = 1; n <= 3; n++) begin
      busAddr = ADDR_W'(n * 40503);
      cyc(1, 0, 0, 0, S_I, "R6");
      for (int w = 0; w < n; w++) begin
        cyc(1, 0, 0, 0, S_W1, "R6");
        cyc((w < n - 1) || (n == 3), (n == 3) && (w == n - 1), 0, 0, S_W2, "R6_R7");
      end
      if (n == 3) begin
        cyc(1, 1, 0, 0, S_R1, "R7");
        cyc(0, 0, 0, 0, S_R2, "R7");
      end
      cyc(0, 0, 0, 0, S_I, "R6");
    end

    // R8: request in read1 held to end of read2
    cyc(1, 1, 0, 0, S_I, "R8");
    cyc(1, 1, 1, 0, S_R1, "R8");
    cyc(1, 1, 0, 0, S_R2, "R8");
    cyc(0, 0, 0, 0, S_F1, "R8_R9");
    cyc(0, 0, 0, 0, S_F2, "R8_R9");
    cyc(0, 0, 0, 0, S_I, "R8");
    // R8: request inside a read-hit run
    cyc(1, 1, 0, 0, S_I, "R8");
    cyc(1, 1, 0, 0, S_R1, "R8");
    cyc(1, 1, 1, 0, S_R2, "R8");
    cyc(1, 1, 0, 0, S_F1, "R8");
    cyc(0, 0, 0, 0, S_F2, "R8");
    cyc(0, 0, 0, 0, S_I, "R8");
    // R8: request in write1, write completes first
    cyc(1, 0, 0, 0, S_I, "R8");
    cyc(1, 0, 1, 0, S_W1, "R8");
    cyc(1, 0, 0, 0, S_W2, "R8");
    cyc(0, 0, 0, 0, S_F1, "R8");
    cyc(0, 0, 0, 0, S_F2, "R8");
    cyc(0, 0, 0, 0, S_I, "R8");

    // R12: host reset in read2 and write2 goes to idle
    cyc(1, 1, 0, 0, S_I, "R12");
    cyc(1, 1, 0, 0, S_R1, "R12");
    cyc(1, 1, 0, 1, S_R2, "R12");
    cyc(0, 0, 0, 0, S_I, "R12");
    cyc(1, 0, 0, 0, S_I, "R12");
    cyc(1, 0, 0, 0, S_W1, "R12");
    cyc(1, 0, 0, 1, S_W2, "R12");
    cyc(0, 0, 0, 0, S_I, "R12");

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule